// File: doc/BRIEF.md
# Keyed Configuration Register Port

This block serves a configuration register space through two consecutive addresses on a simple 8-bit I/O bus. The lower address is the index port and the upper one is the data port. A strap input chooses one of two base addresses. After reset the space is locked. Software opens it by writing a two-byte key to the index port. It then writes a register number to the index port and reads or writes that register through the data port. A single exit byte closes the space again.

The register space has two kinds of register. Registers below offset 0x30 are shared by the whole chip: a device-select register, a read-only chip identifier and a small set of general settings. Offsets from 0x30 upward form a bank that is repeated once per logical device. The device-select register decides which bank the data port reaches. All settings are brought out as flat vectors for the functions that consume them: the general settings, every bank, the enable byte of each device, and a copy of the bank that is currently selected.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the space is locked, the device select is 0, and every general and banked register holds 0x00.
- R2: The space opens only when the index port receives two writes of 0x87 in a row. Any other byte written to the index port between them restarts the sequence.
- R3: While the space is open, writing 0xAA to the index port locks it. That write does not change the stored register number.
- R4: While the space is locked, data-port writes change no register, and reads of either port return 0xFF.
- R5: With the strap low, the index port is at 0x2E and the data port at 0x2F. With the strap high they are at 0x4E and 0x4F. Accesses to any other address change nothing and read 0x00.
- R6: While the space is open, an index-port write stores the register number and an index-port read returns it. Data-port accesses reach the register that number selects. General settings are readable and writable at 0x22 through 0x22+NGLB-1.
- R7: Register 0x20 reads the upper byte of the chip identifier and 0x21 reads the lower byte. The identifier is 0xA23 in the upper 12 bits followed by a 4-bit revision. Writes to these two registers are ignored.
- R8: Register 0x07 holds the device select. Offsets 0x30 through 0x30+NBANK-1 reach the bank of the selected device, and each device keeps its own values.
- R9: Unimplemented offsets read 0x00 and ignore writes. This includes banked offsets while the device select is NDEV or larger.
- R10: dev_en carries offset 0x30 of each device's bank, with device d at bits [8d+7:8d]. bank_cfg carries offset 0x30+r of device d at byte index d*NBANK+r. cur_bank carries the selected device's bank, offset 0x30+r at byte r, and is 0 when no device is selected. glb_cfg carries setting 0x22+g at byte g.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_hi | input | 1 | Base address select (0: 0x2E, 1: 0x4E) |
| io_addr | input | ADDR_W | Bus address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe, sampled on the clock edge |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational while io_rd is high |
| cfg_mode | output | 1 | Space is open |
| sel_dev | output | 8 | Selected logical device |
| glb_cfg | output | NGLB*8 | General settings |
| dev_en | output | NDEV*8 | Enable byte of each device |
| cur_bank | output | NBANK*8 | Bank of the selected device |
| bank_cfg | output | NDEV*NBANK*8 | All banks |

## Verification
The bench builds the block with NDEV=3, NBANK=4, NGLB=8 and CHIP_REV=5. With NDEV=3, a device select of 3 is reachable through the bus, so the out-of-range bank case is exercised. With NGLB=8, offsets 0x2A to 0x2F are unimplemented holes that sit between the general settings and the banks. The revision 5 makes the low nibble of the identifier visible in the low identifier byte (0x35). The strap is changed while the space is open, which exercises a move of the base address.

// File: rtl/sio_cfg_pkg.sv
// Shared constants and types for the keyed configuration port.
// Assumes 8-bit registers and an 8-bit register number.
package sio_cfg_pkg;
    localparam logic [7:0] KEY_ENTER  = 8'h87;
    localparam logic [7:0] KEY_EXIT   = 8'hAA;
    localparam logic [7:0] REG_LDN    = 8'h07;
    localparam logic [7:0] REG_ID_HI  = 8'h20;
    localparam logic [7:0] REG_ID_LO  = 8'h21;
    localparam int         GLB_FIRST  = 8'h22;
    localparam int         BANK_FIRST = 8'h30;
    localparam logic [7:0] BASE_LO    = 8'h2E;
    localparam logic [7:0] BASE_HI    = 8'h4E;
    localparam logic [11:0] ID_FAMILY = 12'hA23;

    typedef enum logic [1:0] {
        KEY_IDLE = 2'd0,
        KEY_HALF = 2'd1,
        KEY_OPEN = 2'd2
    } key_state_e;
endpackage

// File: rtl/sio_unlock.sv
// Unlock sequencer: follows the bytes written to the index port.
// Two 0x87 writes in a row open the space and 0xAA closes it.
// Assumes idx_wr is a one-cycle qualified write to the index port.
module sio_unlock
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       unlocked
);
    key_state_e state;

    // Advance the key sequence on each index-port write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= KEY_IDLE;
        end else if (idx_wr) begin
            case (state)
                KEY_IDLE: if (wdata == KEY_ENTER) state <= KEY_HALF;
                KEY_HALF: state <= (wdata == KEY_ENTER) ? KEY_OPEN : KEY_IDLE;
                KEY_OPEN: if (wdata == KEY_EXIT) state <= KEY_IDLE;
                default:  state <= KEY_IDLE;
            endcase
        end
    end

    assign unlocked = (state == KEY_OPEN);
endmodule

// File: rtl/sio_global_regs.sv
// Shared registers below the banked range: device select, the
// read-only chip identifier and NGLB general settings from 0x22.
// Assumes wr_en is already qualified by the unlocked state.
module sio_global_regs
    import sio_cfg_pkg::*;
#(
    parameter int          NGLB    = 8,
    parameter logic [15:0] CHIP_ID = 16'hA230
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        idx,
    input  logic [7:0]        wdata,
    output logic [7:0]        sel_dev,
    output logic [NGLB*8-1:0] glb_flat,
    output logic [7:0]        rd_data
);
    logic [7:0] glb [NGLB];

    // Device select register.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_dev <= 8'h00;
        else if (wr_en && idx == REG_LDN) sel_dev <= wdata;
    end

    for (genvar g = 0; g < NGLB; g++) begin : g_glb
        // One general setting register.
        always_ff @(posedge clk) begin
            if (!rst_n) glb[g] <= 8'h00;
            else if (wr_en && idx == 8'(GLB_FIRST + g)) glb[g] <= wdata;
        end
        assign glb_flat[g*8 +: 8] = glb[g];
    end

    // Read multiplexer; anything unimplemented reads 0.
    always_comb begin
        rd_data = 8'h00;
        if (idx == REG_LDN)   rd_data = sel_dev;
        if (idx == REG_ID_HI) rd_data = CHIP_ID[15:8];
        if (idx == REG_ID_LO) rd_data = CHIP_ID[7:0];
        for (int g = 0; g < NGLB; g++) begin
            if (idx == 8'(GLB_FIRST + g)) rd_data = glb[g];
        end
    end
endmodule

// File: rtl/sio_dev_banks.sv
// Per-device register banks at offsets 0x30..0x30+NBANK-1. Only the
// bank named by sel_dev is reachable; a select of NDEV or more reaches none.
// Assumes NDEV <= 256 and wr_en is already qualified by the unlocked state.
module sio_dev_banks
    import sio_cfg_pkg::*;
#(
    parameter int NDEV  = 4,
    parameter int NBANK = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [7:0]              idx,
    input  logic [7:0]              wdata,
    input  logic [7:0]              sel_dev,
    output logic [NDEV*NBANK*8-1:0] bank_flat,
    output logic [NBANK*8-1:0]      cur_bank,
    output logic [NDEV*8-1:0]       dev_en,
    output logic [7:0]              rd_data
);
    logic [7:0] regs [NDEV][NBANK];

    for (genvar d = 0; d < NDEV; d++) begin : g_dev
        for (genvar r = 0; r < NBANK; r++) begin : g_reg
            // One banked register of device d.
            always_ff @(posedge clk) begin
                if (!rst_n) regs[d][r] <= 8'h00;
                else if (wr_en && sel_dev == 8'(d) && idx == 8'(BANK_FIRST + r))
                    regs[d][r] <= wdata;
            end
            assign bank_flat[(d*NBANK + r)*8 +: 8] = regs[d][r];
        end
        assign dev_en[d*8 +: 8] = regs[d][0];
    end

    // Selected-bank view and bank read data.
    always_comb begin
        cur_bank = '0;
        rd_data  = 8'h00;
        for (int d = 0; d < NDEV; d++) begin
            if (sel_dev == 8'(d)) begin
                for (int r = 0; r < NBANK; r++) begin
                    cur_bank[r*8 +: 8] = regs[d][r];
                    if (idx == 8'(BANK_FIRST + r)) rd_data = regs[d][r];
                end
            end
        end
    end
endmodule

// File: rtl/sio_cfg_port.sv
// Keyed index/data configuration port. Decodes the two port addresses
// from the strap, holds the register number, gates data access on the
// unlock state and merges read data. Reads are combinational while
// io_rd is high; writes take effect on the clock edge with io_wr high.
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int         ADDR_W   = 16,
    parameter int         NDEV     = 4,
    parameter int         NBANK    = 4,
    parameter int         NGLB     = 8,
    parameter logic [3:0] CHIP_REV = 4'h0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    strap_hi,
    input  logic [ADDR_W-1:0]       io_addr,
    input  logic                    io_rd,
    input  logic                    io_wr,
    input  logic [7:0]              io_wdata,
    output logic [7:0]              io_rdata,
    output logic                    cfg_mode,
    output logic [7:0]              sel_dev,
    output logic [NGLB*8-1:0]       glb_cfg,
    output logic [NDEV*8-1:0]       dev_en,
    output logic [NBANK*8-1:0]      cur_bank,
    output logic [NDEV*NBANK*8-1:0] bank_cfg
);
    localparam logic [15:0] CHIP_ID = {ID_FAMILY, CHIP_REV};

    logic [ADDR_W-1:0] base;
    logic              idx_sel, dat_sel, idx_wr, data_wr;
    logic [7:0]        cfg_idx, glb_rd, bank_rd;

    assign base    = strap_hi ? ADDR_W'(BASE_HI) : ADDR_W'(BASE_LO);
    assign idx_sel = (io_addr == base);
    assign dat_sel = (io_addr == base + ADDR_W'(1));
    assign idx_wr  = io_wr && idx_sel;
    assign data_wr = io_wr && dat_sel && cfg_mode;

    sio_unlock u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .wdata    (io_wdata),
        .unlocked (cfg_mode)
    );

    // Register number, stored only while open; the exit byte is not kept.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_idx <= 8'h00;
        else if (idx_wr && cfg_mode && io_wdata != KEY_EXIT) cfg_idx <= io_wdata;
    end

    sio_global_regs #(.NGLB(NGLB), .CHIP_ID(CHIP_ID)) u_glb (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (data_wr),
        .idx      (cfg_idx),
        .wdata    (io_wdata),
        .sel_dev  (sel_dev),
        .glb_flat (glb_cfg),
        .rd_data  (glb_rd)
    );

    sio_dev_banks #(.NDEV(NDEV), .NBANK(NBANK)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (data_wr),
        .idx       (cfg_idx),
        .wdata     (io_wdata),
        .sel_dev   (sel_dev),
        .bank_flat (bank_cfg),
        .cur_bank  (cur_bank),
        .dev_en    (dev_en),
        .rd_data   (bank_rd)
    );

    // Bus read data: 0xFF from either port while locked, 0 off-window.
    always_comb begin
        io_rdata = 8'h00;
        if (io_rd) begin
            if (idx_sel)      io_rdata = cfg_mode ? cfg_idx : 8'hFF;
            else if (dat_sel) io_rdata = cfg_mode ? (glb_rd | bank_rd) : 8'hFF;
        end
    end
endmodule

// File: rtl/sio_cfg_port_chk.sv
// Protocol checker for sio_cfg_port, attached by bind below.
// Watches the bus, the unlock state and the stored register number.
module sio_cfg_port_chk
    import sio_cfg_pkg::*;
#(
    parameter int          ADDR_W  = 16,
    parameter logic [15:0] CHIP_ID = 16'hA230
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strap_hi,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_rd,
    input logic              io_wr,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              cfg_mode,
    input logic [7:0]        sel_dev,
    input logic [7:0]        cfg_idx
);
    logic [ADDR_W-1:0] ip, dp;
    assign ip = strap_hi ? ADDR_W'(8'h4E) : ADDR_W'(8'h2E);
    assign dp = strap_hi ? ADDR_W'(8'h4F) : ADDR_W'(8'h2F);

    AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_mode) |-> $past(io_wr && io_addr == ip && io_wdata == 8'h87)); // R2
    AST_EXIT_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && io_wr && io_addr == ip && io_wdata == 8'hAA) |=> !cfg_mode); // R3
    AST_LOCKED_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode && io_rd && (io_addr == ip || io_addr == dp)) |-> io_rdata == 8'hFF); // R4
    AST_LOCKED_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode && io_wr && io_addr == dp) |=> $stable(sel_dev)); // R4
    AST_ID_HIGH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && io_rd && io_addr == dp && cfg_idx == 8'h20) |-> io_rdata == CHIP_ID[15:8]); // R7
endmodule

bind sio_cfg_port sio_cfg_port_chk #(.ADDR_W(ADDR_W), .CHIP_ID(CHIP_ID)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .strap_hi (strap_hi),
    .io_addr  (io_addr),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .cfg_mode (cfg_mode),
    .sel_dev  (sel_dev),
    .cfg_idx  (cfg_idx)
);

// File: tb/tb_sio_cfg_port.sv
// Bench: a behavioural model is updated on each bus write and compared
// with all state outputs on every falling edge; reads are checked
// against explicit expected values.
module tb_sio_cfg_port;
    localparam int AW = 16, ND = 3, NB = 4, NG = 8;

    logic clk = 0, rst_n = 0, strap_hi = 0, io_rd = 0, io_wr = 0;
    logic [AW-1:0] io_addr = 0;
    logic [7:0] io_wdata = 0, io_rdata, sel_dev;
    logic cfg_mode;
    logic [NG*8-1:0] glb_cfg;
    logic [ND*8-1:0] dev_en;
    logic [NB*8-1:0] cur_bank;
    logic [ND*NB*8-1:0] bank_cfg;

    sio_cfg_port #(.ADDR_W(AW), .NDEV(ND), .NBANK(NB), .NGLB(NG), .CHIP_REV(4'h5)) dut (
        .clk(clk), .rst_n(rst_n), .strap_hi(strap_hi), .io_addr(io_addr),
        .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .cfg_mode(cfg_mode), .sel_dev(sel_dev), .glb_cfg(glb_cfg), .dev_en(dev_en),
        .cur_bank(cur_bank), .bank_cfg(bank_cfg));

    always #5 clk = ~clk;

    int checks = 0, fails = 0;
    bit cmp_on = 0, done = 0;
    int m_st = 0, m_idx = 0, m_sel = 0;
    int m_glb [NG];
    int m_bank [ND][NB];

    task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference of one bus write.
    task automatic model_write(int a, int d);
        int b;
        b = strap_hi ? 'h4E : 'h2E;
        if (a == b) begin
            if (m_st == 0) m_st = (d == 'h87) ? 1 : 0;
            else if (m_st == 1) m_st = (d == 'h87) ? 2 : 0;
            else if (d == 'hAA) m_st = 0;
            else m_idx = d;
        end else if (a == b + 1 && m_st == 2) begin
            if (m_idx == 7) m_sel = d;
            else if (m_idx >= 'h22 && m_idx < 'h22 + NG) m_glb[m_idx - 'h22] = d;
            else if (m_idx >= 'h30 && m_idx < 'h30 + NB && m_sel < ND)
                m_bank[m_sel][m_idx - 'h30] = d;
        end
    endtask

    // Per-clock comparison of all state outputs with the model.
    always @(negedge clk) begin
        if (cmp_on) begin
            logic [NG*8-1:0] eg;
            logic [ND*8-1:0] ee;
            logic [NB*8-1:0] ec;
            logic [ND*NB*8-1:0] eb;
            eg = '0; ee = '0; ec = '0; eb = '0;
            for (int g = 0; g < NG; g++) eg[g*8 +: 8] = 8'(m_glb[g]);
            for (int d = 0; d < ND; d++) begin
                ee[d*8 +: 8] = 8'(m_bank[d][0]);
                for (int r = 0; r < NB; r++) begin
                    eb[(d*NB + r)*8 +: 8] = 8'(m_bank[d][r]);
                    if (m_sel == d) ec[r*8 +: 8] = 8'(m_bank[d][r]);
                end
            end
            chk("R2 model cfg_mode", 256'(cfg_mode), 256'(m_st == 2));
            chk("R8 model sel_dev", 256'(sel_dev), 256'(m_sel));
            chk("R6 model glb_cfg", 256'(glb_cfg), 256'(eg));
            chk("R10 model dev_en", 256'(dev_en), 256'(ee));
            chk("R10 model cur_bank", 256'(cur_bank), 256'(ec));
            chk("R10 model bank_cfg", 256'(bank_cfg), 256'(eb));
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        io_addr = AW'(a); io_wdata = 8'(d); io_wr = 1;
        @(posedge clk);
        model_write(a, d);
        @(negedge clk);
        io_wr = 0;
    endtask

    task automatic rd(int a, int exp, string tag);
        @(negedge clk);
        io_addr = AW'(a); io_rd = 1;
        #2;
        chk(tag, 256'(io_rdata), 256'(exp));
        @(posedge clk);
        #1 io_rd = 0;
    endtask

    task automatic reg_wr(int r, int d);
        wr('h2E, r);
        wr('h2F, d);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        foreach (m_glb[g]) m_glb[g] = 0;
        foreach (m_bank[d, r]) m_bank[d][r] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        cmp_on = 1;
        // R1: reset state
        @(negedge clk);
        chk("R1 reset cfg_mode", 256'(cfg_mode), 0);
        chk("R1 reset bank_cfg", 256'(bank_cfg), 0);
        // R4: locked space
        rd('h2F, 'hFF, "R4 locked data read");
        rd('h2E, 'hFF, "R4 locked index read");
        wr('h2F, 'h55);
        // R2: interrupted key, then a proper key
        wr('h2E, 'h87); wr('h2E, 'h11); wr('h2E, 'h87);
        chk("R2 interrupted key stays locked", 256'(cfg_mode), 0);
        wr('h2E, 'h87);
        chk("R2 double key opens", 256'(cfg_mode), 1);
        // R6/R7: index read-back and identifier
        wr('h2E, 'h20);
        rd('h2E, 'h20, "R6 index read-back");
        rd('h2F, 'hA2, "R7 id high byte");
        wr('h2E, 'h21);
        rd('h2F, 'h35, "R7 id low byte");
        wr('h2F, 'h00);
        rd('h2F, 'h35, "R7 id write ignored");
        reg_wr('h24, 'h5A);
        rd('h2F, 'h5A, "R6 general setting");
        reg_wr('h29, 'hC3);
        rd('h2F, 'hC3, "R6 last general setting");
        // R8/R10: banks
        reg_wr('h07, 1); reg_wr('h30, 'h03); reg_wr('h31, 'h44);
        reg_wr('h07, 2); reg_wr('h30, 'h81);
        reg_wr('h07, 1);
        wr('h2E, 'h30);
        rd('h2F, 'h03, "R8 bank of device 1 kept");
        wr('h2E, 'h31);
        rd('h2F, 'h44, "R8 second banked offset");
        @(negedge clk);
        chk("R10 dev_en of device 2", 256'(dev_en[23:16]), 'h81);
        chk("R10 cur_bank device 1", 256'(cur_bank), 'h4403);
        // R9: out-of-range device and holes
        reg_wr('h07, 3); reg_wr('h30, 'h77);
        rd('h2F, 'h00, "R9 bank of device beyond NDEV");
        reg_wr('h2F, 'h99);
        rd('h2F, 'h00, "R9 unimplemented global hole");
        reg_wr('h07, 0); reg_wr('h34, 'h12);
        rd('h2F, 'h00, "R9 offset past bank");
        // R5: strap moves the window
        @(negedge clk) strap_hi = 1;
        rd('h2F, 'h00, "R5 old data port dead");
        rd('h4E, 'h34, "R5 new index port");
        rd('h30, 'h00, "R5 unrelated address");
        // R3: exit key keeps register number
        wr('h4E, 'hAA);
        chk("R3 exit key locks", 256'(cfg_mode), 0);
        wr('h4E, 'h87); wr('h4E, 'h87);
        rd('h4E, 'h34, "R3 index kept over exit");
        wr('h4E, 'hAA);
        wr('h2E, 'h87); wr('h2E, 'h87);
        chk("R5 key at old base ignored", 256'(cfg_mode), 0);
        rd('h4E, 'hFF, "R4 locked index read after exit");
        // R1: reset again clears everything
        @(negedge clk) rst_n = 0;
        cmp_on = 0;
        @(negedge clk) rst_n = 1;
        m_st = 0; m_idx = 0; m_sel = 0;
        foreach (m_glb[g]) m_glb[g] = 0;
        foreach (m_bank[d, r]) m_bank[d][r] = 0;
        @(negedge clk);
        chk("R1 reset clears settings", 256'(glb_cfg), 0);
        chk("R1 reset clears enables", 256'(dev_en), 0);
        done = 1;
        summary();
        $finish;
    end
endmodule